// File: doc/BRIEF.md
# 8-bit ALU with Status Flags

This block is the combinational arithmetic and logic unit of a small register machine. It takes two 8-bit operands, the current six status flags and a 4-bit operation code. It returns the 8-bit result, a strobe that says whether the result should be written back, the updated flag vector and a per-flag write mask. The operations are add, add with carry, subtract, subtract with carry, AND, OR, XOR, one's complement, negate, increment, decrement, compare, compare with carry and set-to-all-ones.

Each operation changes only its own subset of flags. Every flag that the operation does not affect is copied from `flags_in` to `flags_out` unchanged. This lets the surrounding pipeline write `flags_out` straight into its status register. The flag vector uses these bit positions: C=bit 0, Z=bit 1, N=bit 2, V=bit 3, S=bit 4, H=bit 5.

Operation codes: 0 ADD, 1 ADC, 2 SUB, 3 SBC, 4 AND, 5 OR, 6 XOR, 7 COM, 8 NEG, 9 INC, 10 DEC, 11 CMP, 12 CPC, 13 SET, 14 and 15 reserved.

Top module: `alu8_core`

## Requirements
- R1: ADD (0) returns opnd_a+opnd_b. ADC (1) also adds flags_in C. C is the carry out of bit 7. Both update C, Z, N, V, S and H.
- R2: SUB (2) returns opnd_a-opnd_b. SBC (3) also subtracts flags_in C. C is set when a borrow occurs. Both update C, Z, N, V, S and H.
- R3: H is the carry out of bit 3 for additions and the borrow out of bit 3 for subtractions and negate.
- R4: V is set on two's complement overflow. N is bit 7 of the result. S equals N XOR V and is written whenever N and V are written.
- R5: AND (4), OR (5) and XOR (6) write Z, N, S and V, with V forced to 0. C and H equal their flags_in values.
- R6: COM (7) returns 0xFF minus opnd_a. It sets C to 1, clears V and updates Z, N and S. H equals its flags_in value.
- R7: NEG (8) returns 0x00 minus opnd_a and updates C, Z, N, V, S and H as that subtraction would.
- R8: INC (9) and DEC (10) return opnd_a plus or minus one. They update Z, N, V and S and leave C and H equal to flags_in.
- R9: CMP (11) and CPC (12) compute the same flags as SUB and SBC and drive result_we low. The result port carries the difference.
- R10: For SBC and CPC, Z is 1 only if the difference is zero and flags_in Z was 1.
- R11: SET (13) returns 0xFF with result_we high and changes no flag. Reserved codes 14 and 15 pass opnd_a through, drive result_we low and change no flag.
- R12: flags_we has bit i high exactly when the operation affects flag i. When flags_we bit i is low, flags_out bit i equals flags_in bit i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 4 | Operation code |
| opnd_a | input | 8 | First operand (the only operand of COM, NEG, INC and DEC) |
| opnd_b | input | 8 | Second operand |
| flags_in | input | 6 | Current flags {H,S,V,N,Z,C} |
| result | output | 8 | Operation result |
| result_we | output | 1 | High when the result is to be written back |
| flags_out | output | 6 | Updated flags {H,S,V,N,Z,C} |
| flags_we | output | 6 | Mask of the flags the operation affects |

## Verification
The block has no register, so every output is due in the same cycle as the stimulus, after combinational settling only. The bench changes the inputs just after a falling clock edge and samples all four outputs 1 ns later, still inside the low half of that cycle. No check therefore depends on an edge or on the order of processes. Flag expectations come from an integer model that works with signed value ranges rather than carry bits. The result column of the vector table was worked out by hand.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  localparam int NFLAG = 6;
  localparam int FL_C  = 0;
  localparam int FL_Z  = 1;
  localparam int FL_N  = 2;
  localparam int FL_V  = 3;
  localparam int FL_S  = 4;
  localparam int FL_H  = 5;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADC  = 4'd1,
    OP_SUB  = 4'd2,
    OP_SBC  = 4'd3,
    OP_AND  = 4'd4,
    OP_OR   = 4'd5,
    OP_XOR  = 4'd6,
    OP_COM  = 4'd7,
    OP_NEG  = 4'd8,
    OP_INC  = 4'd9,
    OP_DEC  = 4'd10,
    OP_CMP  = 4'd11,
    OP_CPC  = 4'd12,
    OP_SET  = 4'd13,
    OP_RSV0 = 4'd14,
    OP_RSV1 = 4'd15
  } alu_op_e;

  typedef enum logic [2:0] {
    CLS_ARITH,
    CLS_LOGIC,
    CLS_COMP,
    CLS_ONES,
    CLS_PASS
  } res_cls_e;

  typedef enum logic [1:0] {
    LF_AND,
    LF_OR,
    LF_XOR,
    LF_NOT
  } logic_fn_e;

  typedef enum logic [1:0] {
    BS_OPND,
    BS_ONE,
    BS_A
  } b_sel_e;

  typedef struct packed {
    res_cls_e          cls;
    logic_fn_e         lfn;
    b_sel_e            bsel;
    logic              zero_a;
    logic              sub;
    logic              use_c;
    logic              sticky_z;
    logic              res_we;
    logic [NFLAG-1:0]  mask;
  } alu_ctl_t;

  localparam logic [NFLAG-1:0] M_ALL   = 6'b111111;
  localparam logic [NFLAG-1:0] M_LOGIC = 6'b011110;
  localparam logic [NFLAG-1:0] M_COMP  = 6'b011111;
  localparam logic [NFLAG-1:0] M_NONE  = 6'b000000;

endpackage

// File: rtl/alu8_decode.sv
module alu8_decode
  import alu8_pkg::*;
(
  input  logic [3:0] op_sel,
  output alu_ctl_t   ctl
);

  alu_op_e op;

  always_comb begin
    op           = alu_op_e'(op_sel);
    ctl.cls      = CLS_ARITH;
    ctl.lfn      = LF_AND;
    ctl.bsel     = BS_OPND;
    ctl.zero_a   = 1'b0;
    ctl.sub      = 1'b0;
    ctl.use_c    = 1'b0;
    ctl.sticky_z = 1'b0;
    ctl.res_we   = 1'b1;
    ctl.mask     = M_ALL;
    case (op)
      OP_ADD: ;
      OP_ADC: ctl.use_c = 1'b1;
      OP_SUB: ctl.sub = 1'b1;
      OP_SBC: begin
        ctl.sub      = 1'b1;
        ctl.use_c    = 1'b1;
        ctl.sticky_z = 1'b1;
      end
      OP_AND: begin
        ctl.cls  = CLS_LOGIC;
        ctl.lfn  = LF_AND;
        ctl.mask = M_LOGIC;
      end
      OP_OR: begin
        ctl.cls  = CLS_LOGIC;
        ctl.lfn  = LF_OR;
        ctl.mask = M_LOGIC;
      end
      OP_XOR: begin
        ctl.cls  = CLS_LOGIC;
        ctl.lfn  = LF_XOR;
        ctl.mask = M_LOGIC;
      end
      OP_COM: begin
        ctl.cls  = CLS_COMP;
        ctl.lfn  = LF_NOT;
        ctl.mask = M_COMP;
      end
      OP_NEG: begin
        ctl.sub    = 1'b1;
        ctl.zero_a = 1'b1;
        ctl.bsel   = BS_A;
      end
      OP_INC: begin
        ctl.bsel = BS_ONE;
        ctl.mask = M_LOGIC;
      end
      OP_DEC: begin
        ctl.bsel = BS_ONE;
        ctl.sub  = 1'b1;
        ctl.mask = M_LOGIC;
      end
      OP_CMP: begin
        ctl.sub    = 1'b1;
        ctl.res_we = 1'b0;
      end
      OP_CPC: begin
        ctl.sub      = 1'b1;
        ctl.use_c    = 1'b1;
        ctl.sticky_z = 1'b1;
        ctl.res_we   = 1'b0;
      end
      OP_SET: begin
        ctl.cls  = CLS_ONES;
        ctl.mask = M_NONE;
      end
      default: begin
        ctl.cls    = CLS_PASS;
        ctl.mask   = M_NONE;
        ctl.res_we = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int W = 8
) (
  input  logic         sub,
  input  logic         ci_en,
  input  logic         c_in,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         half,
  output logic         ovf
);

  localparam int HB = W / 2;

  logic [W-1:0] bx;
  logic         ci;
  logic [W:0]   full;
  logic [HB:0]  low;

  always_comb begin
    bx   = sub ? ~b : b;
    ci   = sub ? ~(ci_en & c_in) : (ci_en & c_in);
    full = {1'b0, a} + {1'b0, bx} + {{W{1'b0}}, ci};
    low  = {1'b0, a[HB-1:0]} + {1'b0, bx[HB-1:0]} + {{HB{1'b0}}, ci};
    sum  = full[W-1:0];
    cout = full[W] ^ sub;
    half = low[HB] ^ sub;
    ovf  = (a[W-1] == bx[W-1]) && (full[W-1] != a[W-1]);
  end

endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic_fn_e    fn,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);

  always_comb begin
    case (fn)
      LF_AND:  y = a & b;
      LF_OR:   y = a | b;
      LF_XOR:  y = a ^ b;
      default: y = ~a;
    endcase
  end

endmodule

// File: rtl/alu8_flags.sv
module alu8_flags
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  res_cls_e         cls,
  input  logic             sticky_z,
  input  logic [NFLAG-1:0] mask,
  input  logic [W-1:0]     y,
  input  logic             carry,
  input  logic             half,
  input  logic             ovf,
  input  logic [NFLAG-1:0] flags_in,
  output logic [NFLAG-1:0] flags_out
);

  logic             is_bool;
  logic [NFLAG-1:0] fresh;

  always_comb begin
    is_bool       = (cls == CLS_LOGIC) || (cls == CLS_COMP);
    fresh[FL_C]   = (cls == CLS_COMP) ? 1'b1 : carry;
    fresh[FL_V]   = is_bool ? 1'b0 : ovf;
    fresh[FL_N]   = y[W-1];
    fresh[FL_Z]   = (y == '0) && (!sticky_z || flags_in[FL_Z]);
    fresh[FL_S]   = fresh[FL_N] ^ fresh[FL_V];
    fresh[FL_H]   = half;
    flags_out     = (fresh & mask) | (flags_in & ~mask);
  end

endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [3:0]       op_sel,
  input  logic [W-1:0]     opnd_a,
  input  logic [W-1:0]     opnd_b,
  input  logic [NFLAG-1:0] flags_in,
  output logic [W-1:0]     result,
  output logic             result_we,
  output logic [NFLAG-1:0] flags_out,
  output logic [NFLAG-1:0] flags_we
);

  alu_ctl_t     ctl;
  logic [W-1:0] as_a;
  logic [W-1:0] as_b;
  logic [W-1:0] as_sum;
  logic         as_cout;
  logic         as_half;
  logic         as_ovf;
  logic [W-1:0] lg_y;

  alu8_decode u_dec (
    .op_sel (op_sel),
    .ctl    (ctl)
  );

  always_comb begin
    as_a = ctl.zero_a ? '0 : opnd_a;
    case (ctl.bsel)
      BS_ONE:  as_b = {{(W-1){1'b0}}, 1'b1};
      BS_A:    as_b = opnd_a;
      default: as_b = opnd_b;
    endcase
  end

  alu8_addsub #(.W(W)) u_as (
    .sub   (ctl.sub),
    .ci_en (ctl.use_c),
    .c_in  (flags_in[FL_C]),
    .a     (as_a),
    .b     (as_b),
    .sum   (as_sum),
    .cout  (as_cout),
    .half  (as_half),
    .ovf   (as_ovf)
  );

  alu8_logic #(.W(W)) u_lg (
    .fn (ctl.lfn),
    .a  (opnd_a),
    .b  (opnd_b),
    .y  (lg_y)
  );

  always_comb begin
    case (ctl.cls)
      CLS_ARITH: result = as_sum;
      CLS_LOGIC,
      CLS_COMP:  result = lg_y;
      CLS_ONES:  result = '1;
      default:   result = opnd_a;
    endcase
    result_we = ctl.res_we;
    flags_we  = ctl.mask;
  end

  alu8_flags #(.W(W)) u_fl (
    .cls       (ctl.cls),
    .sticky_z  (ctl.sticky_z),
    .mask      (ctl.mask),
    .y         (result),
    .carry     (as_cout),
    .half      (as_half),
    .ovf       (as_ovf),
    .flags_in  (flags_in),
    .flags_out (flags_out)
  );

  // Output checks, evaluated only once every input is known.
  always_comb begin
    if (!$isunknown({op_sel, opnd_a, opnd_b, flags_in})) begin
      for (int i = 0; i < NFLAG; i++) begin
        p_untouched_r12: assert (flags_we[i] || (flags_out[i] == flags_in[i]))
          else $error("unaffected flag %0d changed", i);
      end
      if (op_sel == OP_AND || op_sel == OP_OR || op_sel == OP_XOR) begin
        p_logic_v_clear_r5: assert (!flags_out[FL_V] && flags_we[FL_V])
          else $error("logic op left V set");
      end
      if (op_sel == OP_COM) begin
        p_com_carry_r6: assert (flags_out[FL_C] && (flags_out[FL_H] == flags_in[FL_H]))
          else $error("COM carry or half flag wrong");
      end
      if (op_sel == OP_CMP || op_sel == OP_CPC) begin
        p_cmp_no_write_r9: assert (!result_we)
          else $error("compare requested a write");
      end
      if ((op_sel == OP_SBC || op_sel == OP_CPC) && !flags_in[FL_Z]) begin
        p_sticky_z_r10: assert (!flags_out[FL_Z])
          else $error("sticky Z set from clear");
      end
      if (op_sel == OP_SET) begin
        p_set_quiet_r11: assert ((result == '1) && (flags_out == flags_in))
          else $error("SET changed flags or value");
      end
    end
  end

endmodule

// File: tb/sim_alu8_core.sv
module sim_alu8_core;

  localparam time TCK = 4ns;

  logic       clk;
  logic       rst_n;
  logic [3:0] op_sel;
  logic [7:0] opnd_a;
  logic [7:0] opnd_b;
  logic [5:0] flags_in;
  logic [7:0] result;
  logic       result_we;
  logic [5:0] flags_out;
  logic [5:0] flags_we;

  int n_chk;
  int n_bad;
  bit done;

  alu8_core u0 (
    .op_sel    (op_sel),
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .flags_in  (flags_in),
    .result    (result),
    .result_we (result_we),
    .flags_out (flags_out),
    .flags_we  (flags_we)
  );

  initial clk = 1'b0;
  always #(TCK/2) clk = ~clk;

  // vector: {op, a, b, flags_in, expected result, expected result_we}
  localparam int NV = 26;
  localparam logic [34:0] VEC [NV] = '{
    {4'd0,  8'h3A, 8'h46, 6'h00, 8'h80, 1'b1},
    {4'd0,  8'hFF, 8'h01, 6'h00, 8'h00, 1'b1},
    {4'd1,  8'h7F, 8'h00, 6'h01, 8'h80, 1'b1},
    {4'd1,  8'h10, 8'h20, 6'h00, 8'h30, 1'b1},
    {4'd2,  8'h10, 8'h01, 6'h00, 8'h0F, 1'b1},
    {4'd2,  8'h00, 8'h01, 6'h00, 8'hFF, 1'b1},
    {4'd3,  8'h80, 8'h00, 6'h01, 8'h7F, 1'b1},
    {4'd3,  8'h05, 8'h05, 6'h02, 8'h00, 1'b1},
    {4'd3,  8'h05, 8'h05, 6'h00, 8'h00, 1'b1},
    {4'd4,  8'hF0, 8'h3C, 6'h3F, 8'h30, 1'b1},
    {4'd5,  8'h00, 8'h00, 6'h29, 8'h00, 1'b1},
    {4'd6,  8'hAA, 8'hFF, 6'h21, 8'h55, 1'b1},
    {4'd7,  8'h55, 8'h00, 6'h20, 8'hAA, 1'b1},
    {4'd8,  8'h80, 8'h00, 6'h00, 8'h80, 1'b1},
    {4'd8,  8'h00, 8'h00, 6'h01, 8'h00, 1'b1},
    {4'd8,  8'h01, 8'h00, 6'h00, 8'hFF, 1'b1},
    {4'd9,  8'h7F, 8'h00, 6'h21, 8'h80, 1'b1},
    {4'd9,  8'hFF, 8'h00, 6'h00, 8'h00, 1'b1},
    {4'd10, 8'h80, 8'h00, 6'h00, 8'h7F, 1'b1},
    {4'd10, 8'h00, 8'h00, 6'h01, 8'hFF, 1'b1},
    {4'd11, 8'h40, 8'h41, 6'h00, 8'hFF, 1'b0},
    {4'd12, 8'h05, 8'h04, 6'h03, 8'h00, 1'b0},
    {4'd12, 8'h05, 8'h04, 6'h01, 8'h00, 1'b0},
    {4'd13, 8'h12, 8'h34, 6'h15, 8'hFF, 1'b1},
    {4'd14, 8'h9C, 8'h00, 6'h2A, 8'h9C, 1'b0},
    {4'd15, 8'h00, 8'hFF, 6'h3F, 8'h00, 1'b0}
  };

  function automatic string tag(input logic [3:0] op);
    case (op)
      4'd0, 4'd1:             return "R1";
      4'd2, 4'd3:             return "R2";
      4'd4, 4'd5, 4'd6:       return "R5";
      4'd7:                   return "R6";
      4'd8:                   return "R7";
      4'd9, 4'd10:            return "R8";
      4'd11:                  return "R9";
      4'd12:                  return "R10";
      default:                return "R11";
    endcase
  endfunction

  // Integer model: returns {result, result_we, flags_out, flags_we}
  function automatic logic [20:0] model(input logic [3:0] op, input int a,
                                        input int b, input logic [5:0] fi);
    int ci, r, sa, sb, sr, lo;
    logic c, z, n, v, h, we;
    logic [5:0] m, fo;
    ci = int'(fi[0]);
    sa = (a > 127) ? a - 256 : a;
    sb = (b > 127) ? b - 256 : b;
    c = fi[0]; h = fi[5]; v = 1'b0; we = 1'b1; m = 6'h3F; r = 0;
    case (op)
      4'd0, 4'd1: begin
        if (op == 4'd0) ci = 0;
        r = a + b + ci; c = r > 255; r = r % 256;
        lo = (a % 16) + (b % 16) + ci; h = lo > 15;
        sr = sa + sb + ci; v = (sr > 127) || (sr < -128);
      end
      4'd2, 4'd3, 4'd11, 4'd12: begin
        if (op == 4'd2 || op == 4'd11) ci = 0;
        r = a - b - ci; c = r < 0; r = (r + 256) % 256;
        lo = (a % 16) - (b % 16) - ci; h = lo < 0;
        sr = sa - sb - ci; v = (sr > 127) || (sr < -128);
        we = (op == 4'd2 || op == 4'd3);
      end
      4'd4: begin r = a & b; m = 6'b011110; end
      4'd5: begin r = a | b; m = 6'b011110; end
      4'd6: begin r = a ^ b; m = 6'b011110; end
      4'd7: begin r = 255 - a; c = 1'b1; m = 6'b011111; end
      4'd8: begin
        r = 0 - a; c = r < 0; r = (r + 256) % 256;
        lo = 0 - (a % 16); h = lo < 0;
        sr = 0 - sa; v = sr > 127;
      end
      4'd9:  begin r = (a + 1) % 256; v = (sa + 1) > 127; m = 6'b011110; end
      4'd10: begin r = (a + 255) % 256; v = (sa - 1) < -128; m = 6'b011110; end
      4'd13: begin r = 255; m = 6'h00; end
      default: begin r = a; m = 6'h00; we = 1'b0; end
    endcase
    z = (r == 0);
    if (op == 4'd3 || op == 4'd12) z = z && fi[1];
    n = r > 127;
    fo = {h, n ^ v, v, n, z, c};
    return {r[7:0], we, (fo & m) | (fi & ~m), m};
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] op, input logic [7:0] a,
                       input logic [7:0] b, input logic [5:0] fi);
    @(negedge clk);
    op_sel = op; opnd_a = a; opnd_b = b; flags_in = fi;
    #1ns;
  endtask

  task automatic chk_model(input logic [3:0] op, input logic [7:0] a,
                           input logic [7:0] b, input logic [5:0] fi);
    logic [20:0] e;
    e = model(op, int'(a), int'(b), fi);
    chk(tag(op), "result", int'(result), int'(e[20:13]));
    chk(tag(op), "result_we", int'(result_we), int'(e[12]));
    chk("R12", "flags_we", int'(flags_we), int'(e[5:0]));
    chk("R4", "flags_out", int'(flags_out), int'(e[11:6]));
  endtask

  initial begin
    #(TCK * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_bad = 0; done = 1'b0;
    rst_n = 1'b0;
    op_sel = 4'd0; opnd_a = 8'h00; opnd_b = 8'h00; flags_in = 6'h00;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // State out of reset: ADD of zeros gives 0 with Z set and all flags written (R1)
    drive(4'd0, 8'h00, 8'h00, 6'h00);
    chk("R1", "reset result", int'(result), 0);
    chk("R1", "reset flags", int'(flags_out), 6'h02);
    chk("R12", "reset mask", int'(flags_we), 6'h3F);

    // Vector table walk
    for (int i = 0; i < NV; i++) begin
      logic [34:0] v;
      v = VEC[i];
      drive(v[34:31], v[30:23], v[22:15], v[14:9]);
      chk(tag(v[34:31]), "table result", int'(result), int'(v[8:1]));
      chk(tag(v[34:31]), "table result_we", int'(result_we), int'(v[0]));
      chk_model(v[34:31], v[30:23], v[22:15], v[14:9]);
    end

    // Directed corner cases with hand values
    drive(4'd0, 8'h3A, 8'h46, 6'h00);  // 0x80: V, N, H, S=0
    chk("R3", "add half/ovf", int'(flags_out), 6'h2C);
    drive(4'd2, 8'h10, 8'h01, 6'h00);  // 0x0F: half borrow only
    chk("R3", "sub half borrow", int'(flags_out), 6'h20);
    drive(4'd3, 8'h05, 8'h05, 6'h00);  // sticky Z stays clear
    chk("R10", "sbc sticky Z clear", int'(flags_out[1]), 0);
    drive(4'd12, 8'h05, 8'h04, 6'h03); // 5-4-1=0, Z kept
    chk("R10", "cpc sticky Z kept", int'(flags_out[1]), 1);
    chk("R9", "cpc no write", int'(result_we), 0);
    drive(4'd9, 8'hFF, 8'h00, 6'h21);  // INC keeps C and H
    chk("R8", "inc keeps C,H", int'({flags_out[5], flags_out[0]}), 2'b11);
    drive(4'd7, 8'h55, 8'h00, 6'h00);  // COM: C=1, N=1, S=1
    chk("R6", "com flags", int'(flags_out), 6'h15);
    drive(4'd4, 8'hF0, 8'h0F, 6'h3F);  // AND -> 0: Z, V cleared, C,H kept
    chk("R5", "and flags", int'(flags_out), 6'h23);
    drive(4'd8, 8'h80, 8'h00, 6'h00);  // NEG 0x80: C, N, V, S=0
    chk("R7", "neg 0x80 flags", int'(flags_out), 6'h0D);
    drive(4'd13, 8'h00, 8'h00, 6'h2A);
    chk("R11", "set keeps flags", int'(flags_out), 6'h2A);

    // Sweep of every code against the integer model
    for (int op = 0; op < 16; op++) begin
      for (int k = 0; k < 24; k++) begin
        logic [7:0] a, b;
        logic [5:0] fi;
        a  = 8'((k * 37 + op * 11) % 256);
        b  = 8'((k * 91 + 13) % 256);
        fi = 6'((k * 5 + op) % 64);
        drive(op[3:0], a, b, fi);
        chk_model(op[3:0], a, b, fi);
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule